// File: doc/BRIEF.md
# Receive timeout counter

A 16-bit down-counter with a sticky counter-ready flag, meant to sit next to a serial receiver and raise an interrupt when the line has gone quiet. It has two ways of being driven. In normal mode, software start and stop strobes load and halt the counter. In receive-timeout mode, the software strobes are locked out, and every character that the receiver moves from its shift register into its FIFO reloads the counter and sets it running again. If no character arrives before the count runs out, the ready flag goes up.

The counter only moves on cycles where the count enable is high, so the count rate is set outside the block. Entering timeout mode halts the counter and clears the ready flag. Leaving timeout mode changes nothing else: a count that is running keeps running and a pending flag stays set. Software then clears the flag with a stop strobe. All results are registered and can be seen one clock edge after the inputs that cause them.

Top module: `rx_timeout_ctr`

## Requirements
- R1: After reset the count is 0, the ready flag is 0, the block is in normal mode and the counter is halted, so an enabled count clock changes nothing.
- R2: In normal mode a start strobe loads the preload value into the count and starts the counter. After that, every cycle with the count enable high lowers the count by one, and a cycle with the enable low keeps it.
- R3: An enabled cycle in which a running counter already holds 0 sets the ready flag and halts the counter. The count stays at 0. A preload of N therefore raises the flag on the (N+1)-th enabled cycle.
- R4: In normal mode a stop strobe halts the counter at its present value and clears the ready flag.
- R5: A timeout-on strobe halts the counter, holds its value and clears the ready flag. It wins over every other strobe in the same cycle.
- R6: While timeout mode is active, start and stop strobes have no effect on the count or on the ready flag.
- R7: While timeout mode is active, a character-transfer pulse loads the preload value and starts the counter. In normal mode the pulse is ignored.
- R8: A timeout-off strobe leaves the count, the running state and the ready flag as they are. From the next cycle on, start and stop are obeyed again.
- R9: If a reload and a terminal count fall in the same cycle, the reload wins: the count takes the preload value and the ready flag is not set.
- R10: If start and stop arrive in the same normal-mode cycle, start wins: the count is reloaded and the ready flag is left as it was.
- R11: A reload, whether from start or from a character transfer, does not clear a pending ready flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe: load the preload value and run |
| stop_i | input | 1 | Stop strobe: halt and clear the ready flag |
| tmo_on_i | input | 1 | Enter receive-timeout mode |
| tmo_off_i | input | 1 | Leave receive-timeout mode |
| rx_xfer_i | input | 1 | Pulse: a received character has entered the FIFO |
| preload_i | input | CNT_W | Value loaded into the counter on a reload |
| cnt_en_i | input | 1 | Count enable, one decrement per high cycle |
| count_o | output | CNT_W | Current count |
| ready_o | output | 1 | Counter-ready interrupt flag |

## Verification
Every result has a latency of exactly one clock edge, because each output comes straight from a flop. A strobe or an enabled cycle driven after edge k shows up on the outputs just after edge k+1. The bench drives its inputs 1 ns after a rising edge and reads the outputs 1 ns after the next rising edge, so each check sees the edge that its stimulus caused and no other. The expected counts come from arithmetic on the preload value and the number of enabled cycles since the last reload: the count is N minus the number of ticks, clamped at 0, and the flag rises on tick N+1. The sweeps cover several preloads and several enable duty cycles. Directed cycles then put each priority collision on a single edge.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  // what the mode controller asks the counter and flag to do this cycle
  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_LOAD  = 2'd1,
    ACT_HALT  = 2'd2,
    ACT_ENTER = 2'd3
  } rtc_act_e;
endpackage

// File: rtl/rtc_mode_ctl.sv
module rtc_mode_ctl
  import rtc_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     start_i,
  input  logic     stop_i,
  input  logic     tmo_on_i,
  input  logic     tmo_off_i,
  input  logic     rx_xfer_i,
  output logic     tmo_q_o,
  output rtc_act_e act_o
);
  logic tmo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        tmo_q <= 1'b0;
    else if (tmo_on_i)  tmo_q <= 1'b1;
    else if (tmo_off_i) tmo_q <= 1'b0;
  end

  // the lockout follows the registered mode, so a timeout-off strobe frees start/stop from the next cycle
  always_comb begin
    act_o = ACT_NONE;
    if (tmo_on_i)     act_o = ACT_ENTER;
    else if (tmo_q) begin
      if (rx_xfer_i)  act_o = ACT_LOAD;
    end
    else if (start_i) act_o = ACT_LOAD;
    else if (stop_i)  act_o = ACT_HALT;
  end

  assign tmo_q_o = tmo_q;
endmodule

// File: rtl/rtc_down_cnt.sv
module rtc_down_cnt
  import rtc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  rtc_act_e         act_i,
  input  logic [CNT_W-1:0] preload_i,
  input  logic             cnt_en_i,
  output logic [CNT_W-1:0] count_o,
  output logic             run_o,
  output logic             term_o
);
  localparam logic [CNT_W-1:0] CntZero = '0;
  localparam logic [CNT_W-1:0] CntOne  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             tick;

  assign tick   = (act_i == ACT_NONE) && run_q && cnt_en_i;
  assign term_o = tick && (cnt_q == CntZero);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= CntZero;
      run_q <= 1'b0;
    end else begin
      unique case (act_i)
        ACT_LOAD: begin
          cnt_q <= preload_i;
          run_q <= 1'b1;
        end
        ACT_HALT, ACT_ENTER: run_q <= 1'b0;
        default: begin
          if (term_o)    run_q <= 1'b0;
          else if (tick) cnt_q <= cnt_q - CntOne;
        end
      endcase
    end
  end

  assign count_o = cnt_q;
  assign run_o   = run_q;
endmodule

// File: rtl/rtc_ready_flag.sv
module rtc_ready_flag
  import rtc_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  rtc_act_e act_i,
  input  logic     term_i,
  output logic     ready_o
);
  logic rdy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                     rdy_q <= 1'b0;
    else if (act_i == ACT_HALT || act_i == ACT_ENTER) rdy_q <= 1'b0;
    else if (term_i)                                 rdy_q <= 1'b1;
  end

  assign ready_o = rdy_q;
endmodule

// File: rtl/rx_timeout_ctr.sv
module rx_timeout_ctr
  import rtc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             tmo_on_i,
  input  logic             tmo_off_i,
  input  logic             rx_xfer_i,
  input  logic [CNT_W-1:0] preload_i,
  input  logic             cnt_en_i,
  output logic [CNT_W-1:0] count_o,
  output logic             ready_o
);
  rtc_act_e act;
  logic     tmo_q;
  logic     run;
  logic     term;

  rtc_mode_ctl u_mode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .stop_i    (stop_i),
    .tmo_on_i  (tmo_on_i),
    .tmo_off_i (tmo_off_i),
    .rx_xfer_i (rx_xfer_i),
    .tmo_q_o   (tmo_q),
    .act_o     (act)
  );

  rtc_down_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .act_i     (act),
    .preload_i (preload_i),
    .cnt_en_i  (cnt_en_i),
    .count_o   (count_o),
    .run_o     (run),
    .term_o    (term)
  );

  rtc_ready_flag u_flag (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .act_i   (act),
    .term_i  (term),
    .ready_o (ready_o)
  );

  logic unused_run;
  assign unused_run = run;
endmodule

// File: rtl/rtc_checker.sv
module rtc_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             stop_i,
  input logic             tmo_on_i,
  input logic             tmo_off_i,
  input logic             rx_xfer_i,
  input logic [CNT_W-1:0] preload_i,
  input logic             cnt_en_i,
  input logic [CNT_W-1:0] count_o,
  input logic             ready_o,
  input logic             tmo_q
);
  AST_START_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tmo_q && start_i && !tmo_on_i) |=> (count_o == $past(preload_i))); // R2

  AST_FLAG_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> (count_o == '0)); // R3

  AST_STOP_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tmo_q && stop_i && !start_i && !tmo_on_i) |=> !ready_o); // R4

  AST_ENTER_FREEZES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_on_i |=> (!ready_o && count_o == $past(count_o))); // R5

  AST_LOCKOUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmo_q && !tmo_on_i && !rx_xfer_i && !cnt_en_i) |=> ($stable(count_o) && $stable(ready_o))); // R6

  AST_XFER_RELOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmo_q && rx_xfer_i && !tmo_on_i) |=> (count_o == $past(preload_i))); // R7

  AST_EXIT_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmo_q && tmo_off_i && !tmo_on_i && !rx_xfer_i && !cnt_en_i) |=> ($stable(ready_o) && $stable(count_o))); // R8

  AST_RELOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmo_q && rx_xfer_i && !tmo_on_i) |=> (ready_o == $past(ready_o))); // R9
endmodule

bind rx_timeout_ctr rtc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .stop_i    (stop_i),
  .tmo_on_i  (tmo_on_i),
  .tmo_off_i (tmo_off_i),
  .rx_xfer_i (rx_xfer_i),
  .preload_i (preload_i),
  .cnt_en_i  (cnt_en_i),
  .count_o   (count_o),
  .ready_o   (ready_o),
  .tmo_q     (tmo_q)
);

// File: tb/rx_timeout_ctr_bench.sv
`timescale 1ns/1ps
module rx_timeout_ctr_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, stop_i = 1'b0, tmo_on_i = 1'b0, tmo_off_i = 1'b0;
  logic        rx_xfer_i = 1'b0, cnt_en_i = 1'b0;
  logic [15:0] preload_i = '0;
  logic [15:0] count_o;
  logic        ready_o;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  rx_timeout_ctr u_rx_timeout_ctr (
    .clk_i, .rst_ni, .start_i, .stop_i, .tmo_on_i, .tmo_off_i,
    .rx_xfer_i, .preload_i, .cnt_en_i, .count_o, .ready_o
  );

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) step();
    rst_ni = 1'b1;
    step();
    chk("R1 count", count_o, 0); chk("R1 ready", ready_o, 0);
    cnt_en_i = 1'b1; repeat (3) step(); cnt_en_i = 1'b0;
    chk("R1 halted count", count_o, 0); chk("R1 halted ready", ready_o, 0);

    // sweep preload and enable duty cycle in normal mode
    for (int n = 0; n < 7; n++) begin
      for (int d = 1; d < 4; d++) begin
        int ticks;
        stop_i = 1'b1; step(); stop_i = 1'b0;
        chk("R4 clear", ready_o, 0);
        preload_i = 16'(n); start_i = 1'b1; step(); start_i = 1'b0;
        chk("R2 load", count_o, n);
        ticks = 0;
        for (int c = 0; c < (n + 3) * d; c++) begin
          cnt_en_i = (c % d == 0);
          step();
          if (cnt_en_i) ticks++;
          chk("R2 count", count_o, (ticks > n) ? 0 : n - ticks);
          chk("R3 ready", ready_o, (ticks > n) ? 1 : 0);
        end
        cnt_en_i = 1'b0;
      end
    end

    // R10: start and stop together, ready pending
    preload_i = 16'd20; start_i = 1'b1; stop_i = 1'b1; step(); start_i = 1'b0; stop_i = 1'b0;
    chk("R10 count", count_o, 20); chk("R10 ready", ready_o, 1);
    // R4: stop mid-count
    cnt_en_i = 1'b1; repeat (3) step();
    stop_i = 1'b1; step(); stop_i = 1'b0;
    chk("R4 hold", count_o, 17); chk("R4 ready", ready_o, 0);
    repeat (2) step();
    chk("R4 halted", count_o, 17);
    // R7: transfer ignored in normal mode
    cnt_en_i = 1'b0; preload_i = 16'd9; start_i = 1'b1; step(); start_i = 1'b0;
    cnt_en_i = 1'b1; repeat (2) step();
    rx_xfer_i = 1'b1; preload_i = 16'd100; step(); rx_xfer_i = 1'b0;
    chk("R7 ignored", count_o, 6);
    // set up a pending flag then enter timeout mode
    cnt_en_i = 1'b0; preload_i = 16'd1; start_i = 1'b1; step(); start_i = 1'b0;
    cnt_en_i = 1'b1; repeat (2) step();
    chk("R3 ready", ready_o, 1);
    cnt_en_i = 1'b0; preload_i = 16'd30; start_i = 1'b1; step(); start_i = 1'b0;
    chk("R11 start keeps flag", ready_o, 1);
    cnt_en_i = 1'b1; step();
    tmo_on_i = 1'b1; start_i = 1'b1; rx_xfer_i = 1'b1; preload_i = 16'd50; step();
    tmo_on_i = 1'b0; start_i = 1'b0; rx_xfer_i = 1'b0;
    chk("R5 hold", count_o, 29); chk("R5 ready", ready_o, 0);
    repeat (2) step();
    chk("R5 halted", count_o, 29);
    // R6 lockout
    start_i = 1'b1; preload_i = 16'd40; step(); start_i = 1'b0;
    chk("R6 start ignored", count_o, 29);
    cnt_en_i = 1'b0; rx_xfer_i = 1'b1; preload_i = 16'd8; step(); rx_xfer_i = 1'b0;
    chk("R7 reload", count_o, 8);
    cnt_en_i = 1'b1; stop_i = 1'b1; step(); stop_i = 1'b0;
    chk("R6 stop ignored", count_o, 7);
    repeat (7) step();
    chk("R6 running", count_o, 0); chk("R6 ready", ready_o, 0);
    step();
    chk("R3 tmo ready", ready_o, 1); chk("R3 tmo count", count_o, 0);
    // R11 transfer keeps pending flag
    rx_xfer_i = 1'b1; preload_i = 16'd3; step(); rx_xfer_i = 1'b0;
    chk("R11 count", count_o, 3); chk("R11 ready", ready_o, 1);
    step();
    // R8 exit keeps state
    tmo_off_i = 1'b1; step(); tmo_off_i = 1'b0;
    chk("R8 running", count_o, 1); chk("R8 ready", ready_o, 1);
    cnt_en_i = 1'b0; start_i = 1'b1; preload_i = 16'd12; step(); start_i = 1'b0;
    chk("R8 start obeyed", count_o, 12); chk("R8 ready kept", ready_o, 1);
    stop_i = 1'b1; step(); stop_i = 1'b0;
    chk("R8 stop clears", ready_o, 0); chk("R8 stop holds", count_o, 12);
    // R9 reload against terminal
    tmo_on_i = 1'b1; step(); tmo_on_i = 1'b0;
    rx_xfer_i = 1'b1; preload_i = 16'd2; step(); rx_xfer_i = 1'b0;
    cnt_en_i = 1'b1; repeat (2) step();
    chk("R9 at zero", count_o, 0);
    rx_xfer_i = 1'b1; preload_i = 16'd5; step(); rx_xfer_i = 1'b0;
    chk("R9 count", count_o, 5); chk("R9 ready", ready_o, 0);
    repeat (5) step();
    chk("R9 zero", count_o, 0); chk("R9 not yet", ready_o, 0);
    step();
    chk("R3 ready", ready_o, 1);
    // sweep transfers in timeout mode with enable held high
    for (int n = 0; n < 6; n++) begin
      rx_xfer_i = 1'b1; preload_i = 16'(n); step(); rx_xfer_i = 1'b0;
      chk("R7 reload", count_o, n);
      for (int k = 1; k < n + 3; k++) begin
        step();
        chk("R7 count", count_o, (k > n) ? 0 : n - k);
        chk("R11 ready", ready_o, 1);
      end
    end
    cnt_en_i = 1'b0;
    finish_run();
  end
endmodule